// File: doc/BRIEF.md
# Per-Pin Input Glitch and Debounce Filter

This block conditions the inputs of a 32-pin port before they reach the rest of the chip. Every pin first passes through a two-flop synchronizer. Software then chooses, pin by pin, whether the synchronized level goes straight to the output or through a filter. There are two filter kinds. The glitch filter removes single-sample pulses. The debounce filter removes slow bounce such as the chatter of a key or push button. Its timing comes from a slow-clock enable divided by a shared 14-bit divisor.

Configuration uses a small write-only port. Five write addresses set and clear bits in a filter-enable mask and in a filter-kind mask, or load the divisor. Each debounced pin runs a three-state machine:
- `CELL_SETTLED`: the input agrees with the output.
- `CELL_ARMED`: the input differs from the output, and no debounce tick has passed yet.
- `CELL_TIMING`: one debounce tick has passed with the input still different.

The named transitions are:
- settle→arm: the input departs from the output.
- arm→settle and timing→settle (abort): the input returns to the output level.
- arm→timing: a tick arrives.
- timing→settle (accept): a second tick arrives, and the output takes the new level.

The machine is held in `CELL_SETTLED` while the pin is disabled or in glitch mode.

Top module: `pin_input_filter`

## Requirements
- R1: A write to address 0 enables the filter on every pin whose `cfg_wdata` bit is 1. A write to address 1 disables it on every such pin. Pins whose data bit is 0 keep their setting.
- R2: A write to address 2 puts every pin whose data bit is 1 into debounce mode. A write to address 3 returns such pins to glitch mode.
- R3: A pin whose filter is disabled drives `pin_out` with its synchronized input. A change on `pin_in` appears after the second rising clock edge.
- R4: In glitch mode the output takes a new level only when two consecutive synchronized samples hold that level. A pulse lasting one clock sample never reaches the output. A stable change appears after the fourth rising edge.
- R5: A write to address 4 loads `cfg_wdata[13:0]` as the divisor DIV and ignores the bits above it. The debounce period is 2×(DIV+1) `slow_tick` pulses. A divisor write restarts the period count.
- R6: In debounce mode a new level is accepted only after the synchronized input has held it from one debounce tick through the next. Any return to the old level before then cancels the change.
- R7: After reset, all filters are disabled, all pins are in glitch mode, the divisor is 0, and `pin_out` is 0.
- R8: While a pin's filter is disabled, its filter state follows the synchronized input. Enabling the filter on a stable input therefore causes no output change.
- R9: Writes to addresses 5, 6 and 7 change no configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slow_tick | input | 1 | One-cycle enable marking each slow-clock period |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration write address |
| cfg_wdata | input | 32 | Configuration write data (mask or divisor) |
| pin_in | input | 32 | Raw asynchronous pin levels |
| pin_out | output | 32 | Conditioned pin levels |

## Verification
The assertions check, on every cycle, the following:
- In glitch mode, the output never moves while the current sample disagrees with the previous one.
- In debounce mode, the output never moves outside the timing state or without a debounce tick.
- A disabled pin's filter state copies the synchronizer.
- The divider count stays within its limit, and two debounce ticks are never adjacent.
- Writes to unused addresses leave the configuration unchanged.

Only the bench's scenarios can show the rest:
- the exact output latencies;
- that a one-sample pulse is dropped while a two-sample pulse passes;
- that key-style bouncing shorter than a debounce period never changes a pin;
- that enlarging the divisor stretches the wait in proportion.

// File: rtl/pinflt_pkg.sv
package pinflt_pkg;

    // Width of the debounce divisor field
    localparam int unsigned DIV_W  = 14;
    // Width of the configuration address
    localparam int unsigned CFG_AW = 3;

    typedef enum logic [1:0] {
        CELL_SETTLED = 2'd0,
        CELL_ARMED   = 2'd1,
        CELL_TIMING  = 2'd2
    } cell_state_e;

    typedef enum logic [CFG_AW-1:0] {
        CFG_EN_SET  = 3'd0,
        CFG_EN_CLR  = 3'd1,
        CFG_DEB_SET = 3'd2,
        CFG_DEB_CLR = 3'd3,
        CFG_DIV     = 3'd4
    } cfg_addr_e;

    localparam logic [CFG_AW-1:0] CFG_LAST = 3'd4;

endpackage

// File: rtl/pinflt_sync.sv
module pinflt_sync #(
    parameter int unsigned WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

endmodule

// File: rtl/pinflt_prescale.sv
module pinflt_prescale #(
    parameter int unsigned DIV_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             restart,
    input  logic             slow_tick,
    output logic             deb_tick
);

    localparam int unsigned CNT_W = DIV_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;
    logic             at_limit;

    // One debounce period spans 2*(div+1) slow ticks: the count runs 0..2*div+1
    assign limit    = {div, 1'b1};
    assign at_limit = (cnt_q == limit);
    assign deb_tick = slow_tick && at_limit && !restart;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (slow_tick) begin
            if (at_limit) cnt_q <= '0;
            else          cnt_q <= cnt_q + 1'b1;
        end
    end

    // R5: the count never exceeds the period limit
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= limit);

    // R5: a period is never shorter than two slow ticks, so ticks never touch
    p_tick_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        deb_tick |=> !deb_tick);

endmodule

// File: rtl/pinflt_cell.sv
module pinflt_cell
    import pinflt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    input  logic en,
    input  logic deb_mode,
    input  logic deb_tick,
    output logic filt_out
);

    cell_state_e state_q, state_d;
    logic        prev_q;
    logic        filt_q, filt_d;
    logic        differs;

    assign differs = (sync_in != filt_q);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CELL_SETTLED;
        else        state_q <= state_d;
    end

    // Next-state logic for the debounce machine
    always_comb begin
        state_d = state_q;
        if (!en || !deb_mode) begin
            state_d = CELL_SETTLED;
        end else begin
            unique case (state_q)
                CELL_SETTLED: if (differs) state_d = CELL_ARMED;
                CELL_ARMED: begin
                    if (!differs)      state_d = CELL_SETTLED;
                    else if (deb_tick) state_d = CELL_TIMING;
                end
                CELL_TIMING: begin
                    if (!differs || deb_tick) state_d = CELL_SETTLED;
                end
                default: state_d = CELL_SETTLED;
            endcase
        end
    end

    // Output logic: pass-through tracking, glitch vote, or debounce accept
    always_comb begin
        filt_d = filt_q;
        if (!en) begin
            filt_d = sync_in;
        end else if (!deb_mode) begin
            if (sync_in == prev_q) filt_d = sync_in;
        end else if (state_q == CELL_TIMING && differs && deb_tick) begin
            filt_d = sync_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            filt_q <= filt_d;
            prev_q <= sync_in;
        end
    end

    assign filt_out = filt_q;

    // R4: glitch mode holds the output while the last two samples disagree
    p_glitch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !deb_mode && sync_in != prev_q) |=> filt_q == $past(filt_q));

    // R6: debounce output moves only on a tick
    p_deb_tick_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && deb_mode && !deb_tick) |=> filt_q == $past(filt_q));

    // R6: debounce output moves only out of the timing state
    p_deb_timing_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && deb_mode && state_q != CELL_TIMING) |=> filt_q == $past(filt_q));

    // R8: a disabled filter tracks the synchronizer
    p_track_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> filt_q == $past(sync_in));

endmodule

// File: rtl/pin_input_filter.sv
module pin_input_filter
    import pinflt_pkg::*;
#(
    parameter int unsigned NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [NPINS-1:0]  cfg_wdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out
);

    localparam int unsigned DW = (DIV_W < NPINS) ? DIV_W : NPINS;

    logic [NPINS-1:0] filt_en_q;
    logic [NPINS-1:0] deb_sel_q;
    logic [DIV_W-1:0] div_q;
    logic [NPINS-1:0] sync_lvl;
    logic [NPINS-1:0] cell_lvl;
    logic             div_wr;
    logic             deb_tick;

    assign div_wr = cfg_we && (cfg_addr == CFG_DIV);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_en_q <= '0;
            deb_sel_q <= '0;
            div_q     <= '0;
        end else if (cfg_we) begin
            case (cfg_addr)
                CFG_EN_SET:  filt_en_q <= filt_en_q | cfg_wdata;
                CFG_EN_CLR:  filt_en_q <= filt_en_q & ~cfg_wdata;
                CFG_DEB_SET: deb_sel_q <= deb_sel_q | cfg_wdata;
                CFG_DEB_CLR: deb_sel_q <= deb_sel_q & ~cfg_wdata;
                CFG_DIV:     div_q     <= DIV_W'(cfg_wdata[DW-1:0]);
                default:     ;
            endcase
        end
    end

    pinflt_sync #(.WIDTH(NPINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (sync_lvl)
    );

    pinflt_prescale #(.DIV_W(DIV_W)) u_prescale (
        .clk       (clk),
        .rst_n     (rst_n),
        .div       (div_q),
        .restart   (div_wr),
        .slow_tick (slow_tick),
        .deb_tick  (deb_tick)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        pinflt_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .sync_in  (sync_lvl[i]),
            .en       (filt_en_q[i]),
            .deb_mode (deb_sel_q[i]),
            .deb_tick (deb_tick),
            .filt_out (cell_lvl[i])
        );
        assign pin_out[i] = filt_en_q[i] ? cell_lvl[i] : sync_lvl[i];
    end

    // R9: unused addresses leave every configuration field alone
    p_unused_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr > CFG_LAST) |=>
            (filt_en_q == $past(filt_en_q) && deb_sel_q == $past(deb_sel_q)
             && div_q == $past(div_q)));

endmodule

// File: tb/sim_pin_input_filter.sv
`timescale 1ns/1ps
module sim_pin_input_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       req;
    } item_t;
    item_t sb_q[$];

    always #5 clk = ~clk;

    pin_input_filter u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .slow_tick (slow_tick),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out)
    );

    // Slow clock enable: one pulse every four clocks
    initial begin
        forever begin
            repeat (3) @(posedge clk);
            #1 slow_tick = 1'b1;
            @(posedge clk);
            #1 slow_tick = 1'b0;
        end
    end

    // Monitor: compare queued expectations away from the active edge
    always @(negedge clk) begin
        if (sb_q.size() > 0) begin
            item_t it;
            it = sb_q.pop_front();
            checks++;
            if (pin_out !== it.exp) begin
                errors++;
                $display("FAIL %s: pin_out=%h expected=%h at %0t",
                         it.req, pin_out, it.exp, $time);
            end
        end
    end

    task automatic expect_out(input logic [31:0] exp, input string req);
        item_t it;
        it.exp = exp;
        it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic cfg_write(input logic [2:0] a, input logic [31:0] d);
        @(posedge clk);
        #1 cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        #1 cfg_we = 1'b0; cfg_wdata = '0;
    endtask

    initial begin
        #1500000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        expect_out(32'h0, "R7");

        // R3 / R7: filters off after reset, two-edge latency
        pin_in = 32'hA5A5_0F0F;
        step(1);
        expect_out(32'h0, "R3");
        step(1);
        expect_out(32'hA5A5_0F0F, "R3");
        pin_in = 32'h0;
        step(4);
        expect_out(32'h0, "R7");

        // R1: enable glitch filter (default kind, R7) on pins 0 and 1
        cfg_write(3'd0, 32'h0000_0003);
        step(2);
        pin_in = 32'h11;
        step(1);
        pin_in = 32'h0;
        step(1);
        expect_out(32'h10, "R1");
        step(4);
        expect_out(32'h0, "R4");

        // R4: stable change appears after the fourth edge
        pin_in = 32'h3;
        step(3);
        expect_out(32'h0, "R4");
        step(1);
        expect_out(32'h3, "R4");

        // R4: a two-sample low pulse on pin 0 passes
        pin_in = 32'h2;
        step(2);
        pin_in = 32'h3;
        step(2);
        expect_out(32'h2, "R4");
        step(3);
        expect_out(32'h3, "R4");

        // R1: disable pin 0; a one-sample low pulse now passes there only
        cfg_write(3'd1, 32'h1);
        pin_in = 32'h0;
        step(1);
        pin_in = 32'h3;
        step(1);
        expect_out(32'h2, "R1");
        step(3);
        expect_out(32'h3, "R1");

        // R8: enabling on a stable input leaves the output alone
        cfg_write(3'd0, 32'h1);
        expect_out(32'h3, "R8");
        step(3);
        expect_out(32'h3, "R8");

        // R9: unused addresses do not enable pin 2
        cfg_write(3'd5, 32'hFFFF_FFFF);
        cfg_write(3'd6, 32'hFFFF_FFFF);
        cfg_write(3'd7, 32'hFFFF_FFFF);
        pin_in = 32'h7;
        step(1);
        pin_in = 32'h3;
        step(1);
        expect_out(32'h7, "R9");
        step(3);
        expect_out(32'h3, "R9");

        // R5 / R2: divisor 1 (upper bits ignored), pin 0 to debounce
        pin_in = 32'h0;
        step(6);
        expect_out(32'h0, "R2");
        cfg_write(3'd4, 32'hFFFF_C001);
        cfg_write(3'd2, 32'h1);
        pin_in = 32'h3;
        step(4);
        expect_out(32'h2, "R2");
        step(6);
        expect_out(32'h2, "R6");
        step(44);
        expect_out(32'h3, "R6");

        // R6: bounce with low phases shorter than a period never lands
        for (int k = 0; k < 10; k++) begin
            pin_in = 32'h2;
            step(5);
            expect_out(32'h3, "R6");
            pin_in = 32'h3;
            step(5);
        end
        pin_in = 32'h2;
        step(44);
        expect_out(32'h2, "R6");

        // R5: divisor 3 doubles the wait (period 32 clocks here)
        cfg_write(3'd4, 32'h3);
        pin_in = 32'h3;
        step(30);
        expect_out(32'h2, "R5");
        step(45);
        expect_out(32'h3, "R5");

        // R2: clear returns pin 0 to glitch mode
        cfg_write(3'd3, 32'h1);
        pin_in = 32'h2;
        step(3);
        expect_out(32'h3, "R2");
        step(1);
        expect_out(32'h2, "R2");

        step(3);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule